// File: doc/BRIEF.md
# Command/Response Buffer Control Register File

This block is the register front end of a command/response style security-module interface. A host reaches it through a simple register bus carrying an address, an access size in bytes, a write flag and write data. Each access is decoded against a fixed 4 KiB window. The window holds these registers:

- locality handshake bits;
- a ready/idle request pair and the status it drives;
- a cancel register;
- a start register;
- the pointers and sizes of the command and response areas;
- a byte-addressable shared data area at offset 0x80 that runs to the window end (0xF80 bytes).

Writing 1 to the start bit while it is clear arms a command. The block then sends one pulse to a separate execution engine. It keeps the start bit set, and refuses writes to the pointers, sizes and data area, until the engine reports completion. Malformed or unsupported accesses raise an error flag for one cycle and leave all state untouched. Read data and the error flag appear on the cycle after the access.

Top module: `cmdrsp_regfile`

## Requirements
- R1: After reset, the following reads return these values:
  - offset 0x00 (locality state) reads 0x81: bit 0 = established, bit 7 = request valid.
  - offset 0x44 (control status) reads 0x2: bit 1 = idle.
  - the command size (0x58) and the response size (0x64) read 0xF80.
  - the command address (0x5C low, 0x60 high) and the response address (0x68, 64-bit) read BASE_ADDR + 0x80.
- R2: An access is rejected in any of these cases: its size in bytes is not 1, 2, 4 or 8; its address is not a multiple of its size; or its address is 0x1000 or above. A rejected access sets the error flag on the next cycle and changes no state.
- R3: Writes are rejected with the error flag at every offset except these: 0x08, 0x40, 0x48 and 0x4C (each only with size 1, 2 or 4); 0x58 to 0x6F; and 0x80 to 0xFFF.
- R4: A write to 0x08 with bit 1 (give up) set clears the held-locality state, and this bit wins over bit 0. Otherwise bit 0 (request) sets it. Held locality reads as bit 1 of 0x00 and as bit 0 of 0x0C.
- R5: A write to 0x40 updates the idle bit as follows. Bit 0 = 1 with bit 1 = 0 clears idle. Bit 0 = 0 with bit 1 = 1 sets idle. Both set, or both clear, leaves idle unchanged.
- R6: A write with bit 0 of 0x4C set, while start is clear, sets start. The start bit is read back at 0x4C bit 0. The same write gives exactly one pulse on startPulse. A write of 0, or any write while start is set, gives no pulse and no change.
- R7: The start bit stays set until engineDone is high for one cycle, and then it clears.
- R8: While start is set, writes to 0x58 to 0x6F and to 0x80 to 0xFFF are rejected with the error flag, and the stored values are kept.
- R9: Before the control fields are decoded, sub-word write data is moved left by 8 × (offset mod 4). For example, a byte write of 0x01 to 0x41 lands on bit 8 and has no effect.
- R10: Pointer, size and data-area bytes are stored per byte lane. A read of size N at offset A returns bytes A to A+N-1, least significant byte first, zero-extended.
- R11: A write to 0x48 (cancel) completes without error. It changes no register and gives no pulse, and 0x48 reads 0.
- R12: The 64-bit identity register at 0x30 reads 0x1014_1014_0002_5811 and is read-only. Its fields:
  - type = 1 in bits [3:0] and version = 1 in bits [7:4];
  - transfer-size code = 3 in bits [12:11];
  - buffer-interface capability = 1 in bit 14;
  - selector = 1 in bits [18:17];
  - vendor ID = 0x1014 in bits [47:32] and device ID = 0x1014 in bits [63:48];
  - all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset into the window |
| busSize | input | 4 | Access size in bytes |
| busWdata | input | 64 | Write data, right-aligned |
| busRdata | output | 64 | Read data, valid the cycle after a read |
| busErr | output | 1 | Error flag, high the cycle after a rejected access |
| startPulse | output | 1 | One-cycle command start to the engine |
| engineDone | input | 1 | Engine completion, clears start |

## Verification
The locality and ready/idle decoders are driven with all four combinations of their two control bits. The two mixed combinations show which bit has priority. The two agreeing combinations show that no update takes place.

The same control registers are also written with byte and half-word accesses at non-zero lane offsets. These accesses would alter state only if the data were decoded without its lane shift.

The data area and the pointer registers receive overlapping full-width and single-byte writes. They are then read back with narrower accesses, which separates correct byte merging from whole-word overwrites.

The start sequence is tried with these patterns:
- a write of zero;
- a first write of one;
- a repeated write while the command is busy;
- a pointer write and a data-area write while busy;
- completion followed by a fresh write.

Together these show that only a clear-to-set transition arms the engine, and that the engine alone releases it.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;

  localparam int DW        = 64;
  localparam int LANES     = DW / 8;
  localparam int WIN_BYTES = 4096;
  localparam int OFF_W     = $clog2(WIN_BYTES);
  localparam int GRP_W     = OFF_W - 3;

  localparam logic [OFF_W-1:0] OFS_LOC_STATE = 12'h000;
  localparam logic [OFF_W-1:0] OFS_LOC_CTRL  = 12'h008;
  localparam logic [OFF_W-1:0] OFS_LOC_STS   = 12'h00C;
  localparam logic [OFF_W-1:0] OFS_IDENT     = 12'h030;
  localparam logic [OFF_W-1:0] OFS_REQ       = 12'h040;
  localparam logic [OFF_W-1:0] OFS_STS       = 12'h044;
  localparam logic [OFF_W-1:0] OFS_CANCEL    = 12'h048;
  localparam logic [OFF_W-1:0] OFS_START     = 12'h04C;
  localparam logic [OFF_W-1:0] OFS_PTR_LO    = 12'h058;
  localparam logic [OFF_W-1:0] OFS_PTR_END   = 12'h070;
  localparam logic [OFF_W-1:0] OFS_BUF       = 12'h080;

  localparam int BUF_BYTES = WIN_BYTES - int'(OFS_BUF);
  localparam int BUF_WORDS = BUF_BYTES / LANES;

  localparam logic [15:0] VENDOR_ID = 16'h1014;
  localparam logic [15:0] DEVICE_ID = 16'h1014;

  // Field layout of the identity register; bit positions are decoded by host software.
  localparam logic [DW-1:0] IDENT_VALUE = {
    DEVICE_ID, VENDOR_ID,
    8'h00,            // revision
    4'h0,
    1'b0,             // selector lock
    2'd1,             // selector
    2'b00,
    1'b1,             // buffer-interface capable
    1'b0,             // fifo capable
    2'd3,             // transfer size code
    1'b0,
    1'b0,             // idle bypass
    1'b0,             // locality capability
    4'd1,             // version
    4'd1              // type
  };

  typedef struct packed {
    logic             rdEn;
    logic             wrEn;
    logic             errFlag;
    logic [GRP_W-1:0] grp;
    logic [2:0]       byteOff;
    logic [LANES-1:0] byteEn;
    logic [LANES-1:0] szMask;
    logic [DW-1:0]    laneData;
  } strobe_t;

endpackage

// File: rtl/cmdrsp_ctrl.sv
module cmdrsp_ctrl
  import cmdrsp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busSize,
  input  logic [DW-1:0]     busWdata,
  input  logic              engineDone,
  output strobe_t           stb,
  output logic              locHeld,
  output logic              idleBit,
  output logic              startBit,
  output logic              startPulse
);

  logic [OFF_W-1:0] off;
  logic             inWin;
  logic             sizeOk;
  logic [2:0]       alignMask;
  logic [LANES-1:0] szMask;
  logic             aligned;
  logic             isCtrlDw;
  logic             isStoreDw;
  logic             writable;
  logic             goodAcc;
  logic             doWr;
  logic [DW-1:0]    dwShift;
  logic [31:0]      fieldData;

  assign off   = busAddr[OFF_W-1:0];
  assign inWin = (busAddr < ADDR_W'(WIN_BYTES));

  always_comb begin
    sizeOk    = 1'b1;
    alignMask = 3'd0;
    szMask    = '0;
    unique case (busSize)
      4'd1: begin alignMask = 3'd0; szMask = 8'h01; end
      4'd2: begin alignMask = 3'd1; szMask = 8'h03; end
      4'd4: begin alignMask = 3'd3; szMask = 8'h0F; end
      4'd8: begin alignMask = 3'd7; szMask = 8'hFF; end
      default: sizeOk = 1'b0;
    endcase
  end

  assign aligned = ((off[2:0] & alignMask) == 3'd0);

  assign isCtrlDw = (off[OFF_W-1:2] == OFS_LOC_CTRL[OFF_W-1:2]) ||
                    (off[OFF_W-1:2] == OFS_REQ[OFF_W-1:2])      ||
                    (off[OFF_W-1:2] == OFS_CANCEL[OFF_W-1:2])   ||
                    (off[OFF_W-1:2] == OFS_START[OFF_W-1:2]);
  assign isStoreDw = ((off >= OFS_PTR_LO) && (off < OFS_PTR_END)) || (off >= OFS_BUF);

  assign writable = (isCtrlDw && (busSize != 4'd8)) || (isStoreDw && !startBit);
  assign goodAcc  = busValid && sizeOk && aligned && inWin;
  assign doWr     = goodAcc && busWrite && writable;

  // Control fields are decoded on the dword view of the write data.
  assign dwShift   = busWdata << {off[1:0], 3'b000};
  assign fieldData = dwShift[31:0];

  always_comb begin
    stb          = '0;
    stb.rdEn     = goodAcc && !busWrite;
    stb.wrEn     = doWr && isStoreDw;
    stb.errFlag  = busValid && !(goodAcc && (!busWrite || writable));
    stb.grp      = off[OFF_W-1:3];
    stb.byteOff  = off[2:0];
    stb.szMask   = szMask;
    stb.byteEn   = szMask << off[2:0];
    stb.laneData = busWdata << {off[2:0], 3'b000};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locHeld    <= 1'b0;
      idleBit    <= 1'b1;
      startBit   <= 1'b0;
      startPulse <= 1'b0;
    end else begin
      startPulse <= 1'b0;
      if (startBit && engineDone) begin
        startBit <= 1'b0;
      end
      if (doWr) begin
        if (off[OFF_W-1:2] == OFS_LOC_CTRL[OFF_W-1:2]) begin
          if (fieldData[1]) begin
            locHeld <= 1'b0;
          end else if (fieldData[0]) begin
            locHeld <= 1'b1;
          end
        end
        if (off[OFF_W-1:2] == OFS_REQ[OFF_W-1:2]) begin
          if (fieldData[1:0] == 2'b01) begin
            idleBit <= 1'b0;
          end else if (fieldData[1:0] == 2'b10) begin
            idleBit <= 1'b1;
          end
        end
        if ((off[OFF_W-1:2] == OFS_START[OFF_W-1:2]) && fieldData[0] && !startBit) begin
          startBit   <= 1'b1;
          startPulse <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cmdrsp_datapath.sv
module cmdrsp_datapath
  import cmdrsp_pkg::*;
#(
  parameter logic [DW-1:0] BASE_ADDR = 64'h0000_0000_FED4_0000
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic          locHeld,
  input  logic          idleBit,
  input  logic          startBit,
  output logic [DW-1:0] busRdata,
  output logic          busErr
);

  localparam logic [DW-1:0]    BUF_PTR_RST  = BASE_ADDR + DW'(OFS_BUF);
  localparam logic [31:0]      BUF_SIZE_RST = 32'(BUF_BYTES);
  localparam logic [GRP_W-1:0] GRP_BUF      = OFS_BUF[OFF_W-1:3];
  localparam logic [GRP_W-1:0] GRP_PTR0     = OFS_PTR_LO[OFF_W-1:3];
  localparam logic [GRP_W-1:0] GRP_PTR1     = GRP_PTR0 + GRP_W'(1);
  localparam logic [GRP_W-1:0] GRP_PTR2     = GRP_PTR0 + GRP_W'(2);
  localparam int               IDX_W        = $clog2(BUF_WORDS);

  logic [31:0]   cmdSize;
  logic [31:0]   rspSize;
  logic [DW-1:0] cmdAddr;
  logic [DW-1:0] rspAddr;
  logic [DW-1:0] bufMem [BUF_WORDS];

  logic             isBuf;
  logic [IDX_W-1:0] bufIdx;
  logic [GRP_W-1:0] bufOfs;
  logic [DW-1:0]    raw;
  logic [DW-1:0]    rdMask;
  logic [DW-1:0]    ptrGrp0New;
  logic [DW-1:0]    ptrGrp1New;
  logic [DW-1:0]    ptrGrp2New;

  function automatic logic [DW-1:0] mergeLanes(input logic [DW-1:0] oldVal,
                                               input logic [DW-1:0] newVal,
                                               input logic [LANES-1:0] be);
    logic [DW-1:0] res;
    res = oldVal;
    for (int b = 0; b < LANES; b++) begin
      if (be[b]) res[8*b +: 8] = newVal[8*b +: 8];
    end
    return res;
  endfunction

  assign isBuf  = (stb.grp >= GRP_BUF);
  assign bufOfs = stb.grp - GRP_BUF;
  assign bufIdx = bufOfs[IDX_W-1:0];

  assign ptrGrp0New = mergeLanes({cmdAddr[31:0], cmdSize}, stb.laneData, stb.byteEn);
  assign ptrGrp1New = mergeLanes({rspSize, cmdAddr[63:32]}, stb.laneData, stb.byteEn);
  assign ptrGrp2New = mergeLanes(rspAddr, stb.laneData, stb.byteEn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdSize <= BUF_SIZE_RST;
      rspSize <= BUF_SIZE_RST;
      cmdAddr <= BUF_PTR_RST;
      rspAddr <= BUF_PTR_RST;
    end else if (stb.wrEn) begin
      if (stb.grp == GRP_PTR0) begin
        cmdSize       <= ptrGrp0New[31:0];
        cmdAddr[31:0] <= ptrGrp0New[63:32];
      end
      if (stb.grp == GRP_PTR1) begin
        cmdAddr[63:32] <= ptrGrp1New[31:0];
        rspSize        <= ptrGrp1New[63:32];
      end
      if (stb.grp == GRP_PTR2) begin
        rspAddr <= ptrGrp2New;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrEn && isBuf) begin
      for (int b = 0; b < LANES; b++) begin
        if (stb.byteEn[b]) bufMem[bufIdx][8*b +: 8] <= stb.laneData[8*b +: 8];
      end
    end
  end

  always_comb begin
    raw = '0;
    if (isBuf) begin
      raw = bufMem[bufIdx];
    end else begin
      case (stb.grp)
        OFS_LOC_STATE[OFF_W-1:3]: raw = {32'd0, 24'd0, 1'b1, 2'b00, 3'b000, locHeld, 1'b1};
        OFS_LOC_CTRL[OFF_W-1:3]:  raw = {30'd0, 1'b0, locHeld, 32'd0};
        OFS_IDENT[OFF_W-1:3]:     raw = IDENT_VALUE;
        OFS_REQ[OFF_W-1:3]:       raw = {30'd0, idleBit, 1'b0, 32'd0};
        OFS_CANCEL[OFF_W-1:3]:    raw = {31'd0, startBit, 32'd0};
        GRP_PTR0:                 raw = {cmdAddr[31:0], cmdSize};
        GRP_PTR1:                 raw = {rspSize, cmdAddr[63:32]};
        GRP_PTR2:                 raw = rspAddr;
        default:                  raw = '0;
      endcase
    end
  end

  always_comb begin
    rdMask = '0;
    for (int b = 0; b < LANES; b++) begin
      rdMask[8*b +: 8] = {8{stb.szMask[b]}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
      busErr   <= 1'b0;
    end else begin
      busErr <= stb.errFlag;
      if (stb.rdEn) begin
        busRdata <= (raw >> {stb.byteOff, 3'b000}) & rdMask;
      end
    end
  end

endmodule

// File: rtl/cmdrsp_regfile.sv
module cmdrsp_regfile
  import cmdrsp_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [DW-1:0]   BASE_ADDR = 64'h0000_0000_FED4_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busSize,
  input  logic [DW-1:0]     busWdata,
  output logic [DW-1:0]     busRdata,
  output logic              busErr,
  output logic              startPulse,
  input  logic              engineDone
);

  strobe_t stb;
  logic    locHeld;
  logic    idleBit;
  logic    startBit;

  cmdrsp_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busSize   (busSize),
    .busWdata  (busWdata),
    .engineDone(engineDone),
    .stb       (stb),
    .locHeld   (locHeld),
    .idleBit   (idleBit),
    .startBit  (startBit),
    .startPulse(startPulse)
  );

  cmdrsp_datapath #(.BASE_ADDR(BASE_ADDR)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .locHeld (locHeld),
    .idleBit (idleBit),
    .startBit(startBit),
    .busRdata(busRdata),
    .busErr  (busErr)
  );

endmodule

// File: rtl/cmdrsp_regfile_chk.sv
module cmdrsp_regfile_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [3:0]        busSize,
  input logic [63:0]       busWdata,
  input logic              busErr,
  input logic              startPulse,
  input logic              engineDone,
  input logic              startBit,
  input logic              idleBit
);

  p_start_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    startBit && !engineDone |=> startBit);

  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    startBit && engineDone |=> !startBit);

  p_pulse_on_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> (startBit && !$past(startBit)));

  p_rise_gives_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startBit) |-> startPulse);

  p_misalign_err_r2: assert property (@(posedge clk) disable iff (!rstN)
    busValid && (busSize == 4'd2) && busAddr[0] |=> busErr);

  p_busy_reject_r8: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && startBit && (busAddr >= ADDR_W'(12'h080)) &&
    (busAddr < ADDR_W'(4096)) && (busSize == 4'd4) && (busAddr[1:0] == 2'b00) |=> busErr);

  p_idle_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && (busSize == 4'd4) && (busAddr == ADDR_W'(12'h040)) &&
    (busWdata[1:0] == 2'b01) |=> !idleBit);

endmodule

bind cmdrsp_regfile cmdrsp_regfile_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busValid  (busValid),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busSize   (busSize),
  .busWdata  (busWdata),
  .busErr    (busErr),
  .startPulse(startPulse),
  .engineDone(engineDone),
  .startBit  (startBit),
  .idleBit   (idleBit)
);

// File: tb/test_cmdrsp_regfile.sv
module test_cmdrsp_regfile;

  localparam int ADDR_W = 16;
  localparam logic [63:0] BASE = 64'h0000_0000_FED4_0000;
  localparam logic [63:0] PTR_RST = BASE + 64'h80;
  // Identity value assembled field by field from R12.
  localparam logic [63:0] IDENT_EXP = (64'h1014 << 48) | (64'h1014 << 32) |
                                      (64'd1 << 17) | (64'd1 << 14) | (64'd3 << 11) |
                                      (64'd1 << 4) | 64'd1;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [3:0]  size;
    logic [63:0] data;
    logic        expErr;
    logic [63:0] expRd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 52;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h000, 4'd4, 64'h0, 1'b0, 64'h81, 4'd1},                 // R1 locality state
    '{1'b0, 16'h030, 4'd8, 64'h0, 1'b0, IDENT_EXP, 4'd12},             // R12 identity
    '{1'b0, 16'h044, 4'd4, 64'h0, 1'b0, 64'h2, 4'd1},                  // R1 idle
    '{1'b0, 16'h058, 4'd4, 64'h0, 1'b0, 64'hF80, 4'd1},                // R1 cmd size
    '{1'b0, 16'h064, 4'd4, 64'h0, 1'b0, 64'hF80, 4'd1},                // R1 rsp size
    '{1'b0, 16'h05C, 4'd4, 64'h0, 1'b0, PTR_RST & 64'hFFFF_FFFF, 4'd1},// R1 cmd addr lo
    '{1'b0, 16'h060, 4'd4, 64'h0, 1'b0, PTR_RST >> 32, 4'd1},          // R1 cmd addr hi
    '{1'b0, 16'h068, 4'd8, 64'h0, 1'b0, PTR_RST, 4'd1},                // R1 rsp addr
    '{1'b0, 16'h042, 4'd4, 64'h0, 1'b1, 64'h0, 4'd2},                  // R2 misaligned
    '{1'b0, 16'h040, 4'd3, 64'h0, 1'b1, 64'h0, 4'd2},                  // R2 bad size
    '{1'b1, 16'h042, 4'd2, 64'h1, 1'b0, 64'h0, 4'd9},                  // R9 lands on bit 16
    '{1'b0, 16'h044, 4'd4, 64'h0, 1'b0, 64'h2, 4'd9},
    '{1'b1, 16'h041, 4'd2, 64'h1, 1'b1, 64'h0, 4'd2},                  // R2 misaligned write
    '{1'b0, 16'h044, 4'd4, 64'h0, 1'b0, 64'h2, 4'd2},
    '{1'b1, 16'h000, 4'd4, 64'h0, 1'b1, 64'h0, 4'd3},                  // R3 read-only
    '{1'b1, 16'h044, 4'd4, 64'h0, 1'b1, 64'h0, 4'd3},
    '{1'b1, 16'h030, 4'd8, 64'h0, 1'b1, 64'h0, 4'd3},
    '{1'b1, 16'h008, 4'd8, 64'h1, 1'b1, 64'h0, 4'd3},                  // R3 size 8 on control
    '{1'b0, 16'h000, 4'd4, 64'h0, 1'b0, 64'h81, 4'd3},
    '{1'b1, 16'h008, 4'd4, 64'h1, 1'b0, 64'h0, 4'd4},                  // R4 request
    '{1'b0, 16'h000, 4'd4, 64'h0, 1'b0, 64'h83, 4'd4},
    '{1'b0, 16'h00C, 4'd4, 64'h0, 1'b0, 64'h1, 4'd4},
    '{1'b1, 16'h008, 4'd4, 64'h3, 1'b0, 64'h0, 4'd4},                  // R4 give-up wins
    '{1'b0, 16'h00C, 4'd4, 64'h0, 1'b0, 64'h0, 4'd4},
    '{1'b0, 16'h000, 4'd4, 64'h0, 1'b0, 64'h81, 4'd4},
    '{1'b1, 16'h009, 4'd1, 64'h1, 1'b0, 64'h0, 4'd9},                  // R9 lands on bit 8
    '{1'b0, 16'h00C, 4'd4, 64'h0, 1'b0, 64'h0, 4'd9},
    '{1'b1, 16'h040, 4'd4, 64'h1, 1'b0, 64'h0, 4'd5},                  // R5 ready
    '{1'b0, 16'h044, 4'd4, 64'h0, 1'b0, 64'h0, 4'd5},
    '{1'b1, 16'h040, 4'd4, 64'h3, 1'b0, 64'h0, 4'd5},                  // R5 both
    '{1'b0, 16'h044, 4'd4, 64'h0, 1'b0, 64'h0, 4'd5},
    '{1'b1, 16'h040, 4'd4, 64'h2, 1'b0, 64'h0, 4'd5},                  // R5 go idle
    '{1'b0, 16'h044, 4'd4, 64'h0, 1'b0, 64'h2, 4'd5},
    '{1'b1, 16'h040, 4'd4, 64'h0, 1'b0, 64'h0, 4'd5},                  // R5 neither
    '{1'b0, 16'h044, 4'd4, 64'h0, 1'b0, 64'h2, 4'd5},
    '{1'b1, 16'h040, 4'd1, 64'h1, 1'b0, 64'h0, 4'd9},                  // R9 byte at lane 0
    '{1'b0, 16'h044, 4'd4, 64'h0, 1'b0, 64'h0, 4'd9},
    '{1'b1, 16'h080, 4'd8, 64'h1122334455667788, 1'b0, 64'h0, 4'd10},  // R10 data area
    '{1'b1, 16'h082, 4'd1, 64'hAA, 1'b0, 64'h0, 4'd10},
    '{1'b0, 16'h080, 4'd8, 64'h0, 1'b0, 64'h1122334455AA7788, 4'd10},
    '{1'b0, 16'h084, 4'd2, 64'h0, 1'b0, 64'h3344, 4'd10},
    '{1'b1, 16'hFF8, 4'd8, 64'hCAFEF00DDEADBEEF, 1'b0, 64'h0, 4'd10},
    '{1'b0, 16'hFFC, 4'd4, 64'h0, 1'b0, 64'hCAFEF00D, 4'd10},
    '{1'b0, 16'h1000, 4'd4, 64'h0, 1'b1, 64'h0, 4'd2},                 // R2 past window
    '{1'b1, 16'h1000, 4'd4, 64'h5, 1'b1, 64'h0, 4'd2},
    '{1'b1, 16'h05C, 4'd4, 64'h12345678, 1'b0, 64'h0, 4'd10},          // R10 pointer
    '{1'b0, 16'h058, 4'd8, 64'h0, 1'b0, 64'h12345678_00000F80, 4'd10},
    '{1'b1, 16'h048, 4'd4, 64'h1, 1'b0, 64'h0, 4'd11},                 // R11 cancel
    '{1'b0, 16'h048, 4'd8, 64'h0, 1'b0, 64'h0, 4'd11},
    '{1'b0, 16'h044, 4'd4, 64'h0, 1'b0, 64'h0, 4'd11},
    '{1'b1, 16'h04C, 4'd4, 64'h0, 1'b0, 64'h0, 4'd6},                  // R6 write 0
    '{1'b0, 16'h04C, 4'd4, 64'h0, 1'b0, 64'h0, 4'd6}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busValid = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [3:0]        busSize = 4'd4;
  logic [63:0]       busWdata = '0;
  logic [63:0]       busRdata;
  logic              busErr;
  logic              startPulse;
  logic              engineDone = 1'b0;

  int checks = 0;
  int fails = 0;
  int pulseCount = 0;
  logic lastErr;
  logic [63:0] lastRd;

  always #10 clk = ~clk;

  cmdrsp_regfile #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE)) i_cmdrsp_regfile (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr), .startPulse(startPulse),
    .engineDone(engineDone)
  );

  always @(posedge clk) if (rstN && startPulse) pulseCount <= pulseCount + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] addr, input logic [3:0] size,
                        input logic [63:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = addr; busSize = size; busWdata = data;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    lastErr = busErr;
    lastRd = busRdata;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    check(busErr == 1'b0, "R1 err at reset", 64'(busErr), 64'd0);
    check(startPulse == 1'b0, "R1 pulse at reset", 64'(startPulse), 64'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].data);
      check(lastErr == VECS[i].expErr, $sformatf("R%0d err vec %0d", VECS[i].req, i),
            64'(lastErr), 64'(VECS[i].expErr));
      if (!VECS[i].wr && !VECS[i].expErr)
        check(lastRd == VECS[i].expRd, $sformatf("R%0d data vec %0d", VECS[i].req, i),
              lastRd, VECS[i].expRd);
    end
    // R6 R11: no pulse from cancel or from writing 0
    check(pulseCount == 0, "R6 no pulse yet", 64'(pulseCount), 64'd0);

    // R6 arm
    access(1'b1, 16'h04C, 4'd4, 64'h1);
    check(lastErr == 1'b0, "R6 arm err", 64'(lastErr), 64'd0);
    check(startPulse == 1'b1, "R6 pulse visible", 64'(startPulse), 64'd1);
    access(1'b0, 16'h04C, 4'd4, 64'h0);
    check(lastRd == 64'h1, "R6 start reads 1", lastRd, 64'h1);
    access(1'b1, 16'h04C, 4'd1, 64'h1);
    check(pulseCount == 1, "R6 repeat gives no pulse", 64'(pulseCount), 64'd1);
    // R8 busy rejection
    access(1'b1, 16'h058, 4'd4, 64'h10);
    check(lastErr == 1'b1, "R8 size write busy", 64'(lastErr), 64'd1);
    access(1'b1, 16'h080, 4'd1, 64'h55);
    check(lastErr == 1'b1, "R8 buffer write busy", 64'(lastErr), 64'd1);
    access(1'b0, 16'h058, 4'd4, 64'h0);
    check(lastRd == 64'hF80, "R8 size kept", lastRd, 64'hF80);
    access(1'b0, 16'h080, 4'd1, 64'h0);
    check(lastRd == 64'h88, "R8 buffer kept", lastRd, 64'h88);
    // R7 start held until done
    repeat (5) @(negedge clk);
    access(1'b0, 16'h04C, 4'd4, 64'h0);
    check(lastRd == 64'h1, "R7 start held", lastRd, 64'h1);
    engineDone = 1'b1;
    @(negedge clk);
    engineDone = 1'b0;
    access(1'b0, 16'h04C, 4'd4, 64'h0);
    check(lastRd == 64'h0, "R7 start cleared", lastRd, 64'h0);
    // R6 rearm after completion with a byte write
    access(1'b1, 16'h04C, 4'd1, 64'h1);
    @(negedge clk);
    check(pulseCount == 2, "R6 rearm pulse", 64'(pulseCount), 64'd2);
    engineDone = 1'b1;
    @(negedge clk);
    engineDone = 1'b0;
    // R8 writes accepted again once idle
    access(1'b1, 16'h058, 4'd4, 64'h10);
    check(lastErr == 1'b0, "R8 write after done", 64'(lastErr), 64'd0);
    access(1'b0, 16'h058, 4'd2, 64'h0);
    check(lastRd == 64'h10, "R10 size readback", lastRd, 64'h10);

    summary();
  end

endmodule